// File: doc/BRIEF.md
# Unicast Destination Address Filter

This block decides whether a received Ethernet frame is kept, by comparing its 48-bit destination address with one stored station address. Frame bytes arrive one per cycle, qualified by `rxValid`, with `rxSof` marking the first byte. The six destination bytes are compared in arrival order against the stored bytes 0 to 5. One cycle after the sixth byte, a single-cycle `decValid` pulse comes out together with the accept flag, a unicast flag and a 2-bit reason code.

The station address sits in two 32-bit words on a small word-addressed register bus. A control word and a CAM-enable word sit next to them. At reset the two address words are loaded from the parameter `DEFAULT_STATION`. After that the address exists only in those words: software can overwrite it, and every comparison uses whatever the words hold when each byte arrives. The control word holds three bits. One enables the comparison, one accepts every unicast frame without looking at the address, and one inverts the match result.

Frames whose first destination byte has bit 0 set are group-addressed. For these the block reports "not unicast" and leaves any further handling to other logic.

Top module: `ucastFilter`

## Requirements
- R1: The station-high word (bus address 2) holds address byte 0 in bits 31:24, byte 1 in 23:16, byte 2 in 15:8 and byte 3 in 7:0. Byte 0 is the first destination byte on the wire.
- R2: The station-low word (bus address 3) holds address byte 4 in bits 31:24 and byte 5 in bits 23:16. Bits 15:0 are stored and read back, but they take no part in the comparison.
- R3: Reset loads both station words from `DEFAULT_STATION`, which is written most significant byte first, in the layout of R1 and R2 with the low 16 bits zero. Reset clears the control word and the CAM-enable word, and holds `decValid` low.
- R4: A bus write changes only the addressed word. Later frames are compared against the words as last written.
- R5: With control bit 1 (accept-all-unicast) set, every unicast frame is accepted with reason 1. This takes precedence over the address comparison and over the complement bit.
- R6: A match requires all three of: control bit 0 (compare enable) set, CAM-enable bit 0 set, and all six destination bytes equal to stored bytes 0 to 5. With no other control bit set, a match gives accept with reason 2 and anything else gives reject with reason 0.
- R7: CAM-enable bits 31:1 are stored and read back but have no effect on any decision.
- R8: With control bit 2 (complement) set and bit 1 clear, accept is the inverse of the match result. An accept reached this way has reason 3, and a reject has reason 0.
- R9: A frame whose first destination byte has bit 0 set gives `decUnicast`=0, `decAccept`=0 and reason 0, whatever the control bits are.
- R10: `decValid` is high for exactly one cycle: the cycle after the sixth destination byte is taken. Bytes that follow without a new `rxSof` produce no further decision.
- R11: A frame that gets fewer than six bytes before the next `rxSof` produces no decision. That `rxSof` starts a fresh comparison.
- R12: Bus address 0 reads the control word in bits 2:0 and zero above them. Address 1 reads the full 32-bit CAM-enable word. `busRdata` follows `busAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Word address: 0 control, 1 CAM enable, 2 station high, 3 station low |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| rxValid | input | 1 | Frame byte valid |
| rxSof | input | 1 | First byte of a frame |
| rxByte | input | 8 | Frame byte |
| decValid | output | 1 | One-cycle decision strobe |
| decUnicast | output | 1 | Destination is an individual address |
| decAccept | output | 1 | Frame accepted |
| decReason | output | 2 | 0 reject, 1 accept-all, 2 address match, 3 complemented accept |

## Verification
The decision outputs are registered once. They are due in the first cycle after the clock edge that takes the sixth byte, and `decValid` must be low again one cycle after that. The bench drives inputs on the falling edge and samples on the next falling edge, so it reads the result exactly in its cycle. It then samples one cycle later to confirm the pulse has ended. Register reads are combinational and are sampled shortly after the address settles, with no edge in between. The cases where no decision is expected are checked on every cycle of their window.

// File: rtl/ucastFilterPkg.sv
package ucastFilterPkg;
  localparam int MAC_BYTES = 6;
  localparam int BYTE_W    = 8;
  localparam int REG_W     = 32;
  localparam int BUS_AW    = 2;
  localparam int MAC_W     = MAC_BYTES * BYTE_W;
  localparam int CNT_W     = $clog2(MAC_BYTES + 1);
  localparam int CTL_W     = 3;

  localparam logic [BUS_AW-1:0] ADR_CTRL = 2'd0;
  localparam logic [BUS_AW-1:0] ADR_CAM  = 2'd1;
  localparam logic [BUS_AW-1:0] ADR_HIGH = 2'd2;
  localparam logic [BUS_AW-1:0] ADR_LOW  = 2'd3;

  localparam int CTL_CMP_EN  = 0;
  localparam int CTL_PROMISC = 1;
  localparam int CTL_INVERT  = 2;

  typedef enum logic [1:0] {
    RSN_REJECT   = 2'd0,
    RSN_PROMISC  = 2'd1,
    RSN_MATCH    = 2'd2,
    RSN_INVERTED = 2'd3
  } reason_e;

  typedef struct packed {
    logic             cmp;
    logic             first;
    logic [CNT_W-1:0] idx;
    logic             issue;
  } strobe_t;
endpackage

// File: rtl/ucastFilterCtl.sv
module ucastFilterCtl
  import ucastFilterPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rxValid,
  input  logic    rxSof,
  output strobe_t strb
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAC_BYTES - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(MAC_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic             inFrame;

  assign inFrame = (byteCnt != '0) && (byteCnt < DONE_CNT);

  always_comb begin
    strb = '0;
    if (rxValid) begin
      if (rxSof) begin
        strb.cmp   = 1'b1;
        strb.first = 1'b1;
        strb.idx   = '0;
      end else if (inFrame) begin
        strb.cmp   = 1'b1;
        strb.idx   = byteCnt;
        strb.issue = (byteCnt == LAST_IDX);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCnt <= '0;
    end else if (strb.first) begin
      byteCnt <= CNT_W'(1);
    end else if (strb.cmp) begin
      byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    byteCnt <= DONE_CNT); // R11

  AST_SOF_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (rxValid && rxSof) |=> (byteCnt == CNT_W'(1))); // R11

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (byteCnt == DONE_CNT && !(rxValid && rxSof)) |=> (byteCnt == DONE_CNT)); // R10
endmodule

// File: rtl/ucastFilterDp.sv
module ucastFilterDp
  import ucastFilterPkg::*;
#(
  parameter logic [MAC_W-1:0] DEFAULT_STATION = 48'h02_11_22_33_44_55
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [BYTE_W-1:0] rxByte,
  input  strobe_t           strb,
  output logic              decValid,
  output logic              decUnicast,
  output logic              decAccept,
  output logic [1:0]        decReason
);
  localparam int LOW_PAD = 2 * REG_W - MAC_W;

  logic [CTL_W-1:0]  ctrlReg;
  logic [REG_W-1:0]  camEnReg;
  logic [REG_W-1:0]  stationHigh;
  logic [REG_W-1:0]  stationLow;

  logic [MAC_W-1:0]  stationAddr;
  logic [BYTE_W-1:0] stationLane [MAC_BYTES];
  logic [BYTE_W-1:0] laneSel;
  logic              byteEq;
  logic              runEq;
  logic              groupBit;
  logic              finalEq;
  logic              matchHit;
  logic              nextAccept;
  reason_e           nextReason;

  // register bank
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg     <= '0;
      camEnReg    <= '0;
      stationHigh <= DEFAULT_STATION[MAC_W-1 -: REG_W];
      stationLow  <= {DEFAULT_STATION[MAC_W-REG_W-1:0], {LOW_PAD{1'b0}}};
    end else if (busWe) begin
      case (busAddr)
        ADR_CTRL: ctrlReg     <= busWdata[CTL_W-1:0];
        ADR_CAM:  camEnReg    <= busWdata;
        ADR_HIGH: stationHigh <= busWdata;
        default:  stationLow  <= busWdata;
      endcase
    end
  end

  always_comb begin
    case (busAddr)
      ADR_CTRL: busRdata = {{(REG_W-CTL_W){1'b0}}, ctrlReg};
      ADR_CAM:  busRdata = camEnReg;
      ADR_HIGH: busRdata = stationHigh;
      default:  busRdata = stationLow;
    endcase
  end

  // byte lanes of the live station address
  assign stationAddr = {stationHigh, stationLow[REG_W-1 -: (MAC_W-REG_W)]};

  for (genvar g = 0; g < MAC_BYTES; g++) begin : gLane
    assign stationLane[g] = stationAddr[MAC_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    laneSel = '0;
    for (int i = 0; i < MAC_BYTES; i++) begin
      if (strb.idx == CNT_W'(i)) laneSel = stationLane[i];
    end
  end

  assign byteEq = (rxByte == laneSel);

  // running comparison
  always_ff @(posedge clk) begin
    if (rst) begin
      runEq    <= 1'b0;
      groupBit <= 1'b0;
    end else if (strb.cmp) begin
      if (strb.first) begin
        runEq    <= byteEq;
        groupBit <= rxByte[0];
      end else begin
        runEq    <= runEq & byteEq;
      end
    end
  end

  assign finalEq  = runEq & byteEq;
  assign matchHit = ctrlReg[CTL_CMP_EN] & camEnReg[0] & finalEq;

  always_comb begin
    if (groupBit) begin
      nextAccept = 1'b0;
      nextReason = RSN_REJECT;
    end else if (ctrlReg[CTL_PROMISC]) begin
      nextAccept = 1'b1;
      nextReason = RSN_PROMISC;
    end else if (ctrlReg[CTL_INVERT]) begin
      nextAccept = ~matchHit;
      nextReason = matchHit ? RSN_REJECT : RSN_INVERTED;
    end else begin
      nextAccept = matchHit;
      nextReason = matchHit ? RSN_MATCH : RSN_REJECT;
    end
  end

  // decision register
  always_ff @(posedge clk) begin
    if (rst) begin
      decValid   <= 1'b0;
      decUnicast <= 1'b0;
      decAccept  <= 1'b0;
      decReason  <= RSN_REJECT;
    end else begin
      decValid <= strb.issue;
      if (strb.issue) begin
        decUnicast <= ~groupBit;
        decAccept  <= nextAccept;
        decReason  <= nextReason;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    decValid |=> !decValid); // R10

  AST_GROUP_REJECT: assert property (@(posedge clk) disable iff (rst)
    (decValid && !decUnicast) |-> (!decAccept && decReason == RSN_REJECT)); // R9

  AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (rst)
    (decValid && decUnicast && $past(ctrlReg[CTL_PROMISC]))
      |-> (decAccept && decReason == RSN_PROMISC)); // R5

  AST_MATCH_GATED: assert property (@(posedge clk) disable iff (rst)
    (decValid && decReason == RSN_MATCH)
      |-> ($past(camEnReg[0]) && $past(ctrlReg[CTL_CMP_EN]))); // R6

  AST_INVERT_NO_MATCH_CODE: assert property (@(posedge clk) disable iff (rst)
    (decValid && $past(ctrlReg[CTL_INVERT])) |-> (decReason != RSN_MATCH)); // R8

  AST_WRITE_ONLY_TARGET: assert property (@(posedge clk) disable iff (rst)
    (busWe && busAddr != ADR_HIGH) |=> $stable(stationHigh)); // R4
endmodule

// File: rtl/ucastFilter.sv
module ucastFilter
  import ucastFilterPkg::*;
#(
  parameter logic [47:0] DEFAULT_STATION = 48'h02_11_22_33_44_55
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        busWe,
  input  logic [1:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic [7:0]  rxByte,
  output logic        decValid,
  output logic        decUnicast,
  output logic        decAccept,
  output logic [1:0]  decReason
);
  strobe_t strb;

  ucastFilterCtl uCtl (
    .clk     (clk),
    .rst     (rst),
    .rxValid (rxValid),
    .rxSof   (rxSof),
    .strb    (strb)
  );

  ucastFilterDp #(.DEFAULT_STATION(DEFAULT_STATION)) uDp (
    .clk        (clk),
    .rst        (rst),
    .busWe      (busWe),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .rxByte     (rxByte),
    .strb       (strb),
    .decValid   (decValid),
    .decUnicast (decUnicast),
    .decAccept  (decAccept),
    .decReason  (decReason)
  );
endmodule

// File: tb/ucastFilter_test.sv
module ucastFilter_test;
  localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
  localparam logic [47:0] OTHER   = 48'h0A_BB_CC_DD_EE_FF;

  typedef struct packed {
    logic [2:0]  ctrl;
    logic [31:0] cam;
    logic [47:0] dst;
    logic        uni;
    logic        acc;
    logic [1:0]  rsn;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 32'h1,         STATION,            1'b1, 1'b1, 2'd2}, // R6 match
    '{3'd1, 32'h1,         48'h02112233_4456,  1'b1, 1'b0, 2'd0}, // R6 last byte differs
    '{3'd1, 32'h1,         48'h04112233_4455,  1'b1, 1'b0, 2'd0}, // R6 first byte differs
    '{3'd0, 32'h1,         STATION,            1'b1, 1'b0, 2'd0}, // R6 compare off
    '{3'd1, 32'h0,         STATION,            1'b1, 1'b0, 2'd0}, // R6 entry off
    '{3'd1, 32'hFFFF_FFFE, STATION,            1'b1, 1'b0, 2'd0}, // R7 upper bits only
    '{3'd1, 32'hFFFF_FFFF, STATION,            1'b1, 1'b1, 2'd2}, // R7 all bits
    '{3'd3, 32'h0,         OTHER,              1'b1, 1'b1, 2'd1}, // R5 promisc
    '{3'd5, 32'h1,         STATION,            1'b1, 1'b0, 2'd0}, // R8 inverted match
    '{3'd5, 32'h1,         OTHER,              1'b1, 1'b1, 2'd3}, // R8 inverted miss
    '{3'd4, 32'h0,         STATION,            1'b1, 1'b1, 2'd3}, // R8 no gate, inverted
    '{3'd1, 32'h1,         48'h03112233_4455,  1'b0, 1'b0, 2'd0}, // R9 group
    '{3'd2, 32'h1,         48'hFFFFFFFF_FFFF,  1'b0, 1'b0, 2'd0}, // R9 group with promisc
    '{3'd6, 32'h1,         STATION,            1'b1, 1'b1, 2'd1}  // R5 beats invert
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic        rxSof = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        decValid, decUnicast, decAccept;
  logic [1:0]  decReason;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  ucastFilter #(.DEFAULT_STATION(STATION)) uut (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rxValid(rxValid), .rxSof(rxSof), .rxByte(rxByte),
    .decValid(decValid), .decUnicast(decUnicast), .decAccept(decAccept),
    .decReason(decReason)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busReadCheck(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    check(busRdata === exp, req, "register read", 64'(busRdata), 64'(exp));
  endtask

  task automatic sendBytes(input logic [47:0] dst, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1;
      rxSof   = (i == 0);
      rxByte  = dst[47-8*i -: 8];
    end
  endtask

  task automatic runFrame(input logic [47:0] dst, input logic eUni, input logic eAcc,
                          input logic [1:0] eRsn, input string req);
    sendBytes(dst, 6);
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0;
    check(decValid === 1'b1, "R10", "decValid after sixth byte", 64'(decValid), 64'd1);
    check(decUnicast === eUni, req, "decUnicast", 64'(decUnicast), 64'(eUni));
    check(decAccept === eAcc, req, "decAccept", 64'(decAccept), 64'(eAcc));
    check(decReason === eRsn, req, "decReason", 64'(decReason), 64'(eRsn));
    @(negedge clk);
    check(decValid === 1'b0, "R10", "decValid one cycle only", 64'(decValid), 64'd0);
  endtask

  task automatic idleNoDecision(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0; rxSof = 1'b0;
      check(decValid === 1'b0, req, "no decision expected", 64'(decValid), 64'd0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(decValid === 1'b0, "R3", "decValid in reset", 64'(decValid), 64'd0);
    rst = 1'b0;

    // reset state and layout
    busReadCheck(2'd2, 32'h0211_2233, "R1");
    busReadCheck(2'd3, 32'h4455_0000, "R2");
    busReadCheck(2'd0, 32'h0, "R3");
    busReadCheck(2'd1, 32'h0, "R3");

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      busWrite(2'd0, {29'd0, VEC[v].ctrl});
      busWrite(2'd1, VEC[v].cam);
      runFrame(VEC[v].dst, VEC[v].uni, VEC[v].acc, VEC[v].rsn, "R6/R5/R7/R8/R9 vector");
    end

    // register map readback
    busWrite(2'd0, 32'hFFFF_FFFF);
    busReadCheck(2'd0, 32'h0000_0007, "R12");
    busWrite(2'd1, 32'hA5A5_0003);
    busReadCheck(2'd1, 32'hA5A5_0003, "R12");
    busReadCheck(2'd2, 32'h0211_2233, "R4");

    // new station address via bus
    busWrite(2'd0, 32'h1);
    busWrite(2'd1, 32'h1);
    busWrite(2'd2, 32'h0A0B_0C0D);
    busWrite(2'd3, 32'h0E0F_1234);
    busReadCheck(2'd2, 32'h0A0B_0C0D, "R4");
    busReadCheck(2'd3, 32'h0E0F_1234, "R2");
    runFrame(48'h0A0B0C0D_0E0F, 1'b1, 1'b1, 2'd2, "R4");
    runFrame(STATION, 1'b1, 1'b0, 2'd0, "R4");
    // bits 15:0 of the low word do not take part
    busWrite(2'd3, 32'h0E0F_0000);
    runFrame(48'h0A0B0C0D_0E0F, 1'b1, 1'b1, 2'd2, "R2");

    // trailing bytes give no second decision
    sendBytes(48'h0A0B0C0D_0E0F, 6);
    @(negedge clk);
    rxValid = 1'b1; rxSof = 1'b0; rxByte = 8'h77;
    check(decValid === 1'b1, "R10", "decision with trailing bytes", 64'(decValid), 64'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rxByte = 8'h78 + 8'(i);
      check(decValid === 1'b0, "R10", "no decision on trailing byte", 64'(decValid), 64'd0);
    end
    idleNoDecision(2, "R10");

    // short frame, then restart
    sendBytes(48'h0A0B0C0D_0E0F, 4);
    idleNoDecision(4, "R11");
    sendBytes(48'h0A0B0C0D_0E0F, 5);
    check(decValid === 1'b0, "R11", "truncated frame", 64'(decValid), 64'd0);
    runFrame(48'h0A0B0C0D_0E0F, 1'b1, 1'b1, 2'd2, "R11");

    // second reset restores the default
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    busReadCheck(2'd2, 32'h0211_2233, "R3");
    busReadCheck(2'd3, 32'h4455_0000, "R3");
    busReadCheck(2'd1, 32'h0, "R3");
    busWrite(2'd0, 32'h1);
    busWrite(2'd1, 32'h1);
    runFrame(STATION, 1'b1, 1'b1, 2'd2, "R3");

    doneFlag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule